// File: doc/BRIEF.md
# Per-Cycle Dead-Time Calculator with Soft-Switching Verdict

This block sits between the phase and current measurement front end and the drive pulse scheduler of a resonant bridge inverter. For every switching cycle it takes one measurement sample. The sample holds four values: the time between the drive-derived voltage edge and the current zero crossing, the switching period, the peak resonant current and the input voltage. From these the block computes the shortest dead time that lets the switch output capacitance swing fully from rail to rail. It then adds a fixed safety margin, limits the result to a programmable ceiling and hands it to the scheduler.

Two further results come from the same calculation. The first is half the applied dead time, which the scheduler uses to delay the inverted drive signal when it builds the reference voltage edge. The second is a soft-switching verdict: the cycle counts as zero-voltage switched when the measured phase time is at least half the dead time. This verdict needs no extra sensing hardware.

The minimum dead time follows an arcsine law: D = (T/π)·asin(a), where a = Vin·ω·Coss·|sin φ| / Ipk, ω = 2π/T and φ = 2π·t_phase/T. Coss, the time tick and the input LSB sizes are all folded into a single scale parameter. The calculation is a four-stage pipeline at one sample per clock, so it finishes well inside a 250 ns switching cycle.

Top module: `zvs_deadtime_calc`

## Requirements
- R1: Each clock cycle with `meas_valid` high produces exactly one single-cycle `out_valid` pulse. The pulse comes 4 clock edges later, results appear in input order, and back-to-back samples on consecutive cycles are all accepted.
- R2: When no clamp applies, `dead_time` equals floor((T/π)·asin(a)) + MARGIN to within 16 ticks. Here T = `period`, a = ARG_SCALE·`v_in`·|sin φ| / (`i_peak`·T·4096) and φ = 2π·`t_phase`/T.
- R3: Only the magnitude of sin φ is used. Phase times giving φ, π−φ, π+φ and 2π−φ all yield the same dead time.
- R4: When a ≥ 1 or `i_peak` = 0, the arcsine saturates to π/2, so the minimum dead time becomes floor(T/2). In that case `zvs_ok` is 0.
- R5: When the margined dead time exceeds `dt_limit`, `dead_time` equals `dt_limit` and `clamped` is 1. Otherwise `clamped` is 0.
- R6: `half_dead` equals floor(`dead_time`/2) for the same sample.
- R7: `zvs_ok` is 1 exactly when the sample is not saturated and `t_phase` ≥ `half_dead`.
- R8: `dead_time`, `half_dead`, `clamped` and `zvs_ok` keep their values in every cycle without `out_valid`.
- R9: While `rst` is high and after it falls, before the first result, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| meas_valid | input | 1 | Measurement sample present this cycle |
| t_phase | input | 16 | Voltage-to-current phase time, ticks |
| period | input | 16 | Switching period, ticks |
| i_peak | input | 12 | Peak resonant current, LSB units |
| v_in | input | 12 | Input voltage, LSB units |
| dt_limit | input | 16 | Dead-time ceiling, ticks |
| out_valid | output | 1 | Result strobe |
| dead_time | output | 16 | Applied dead time, ticks |
| half_dead | output | 16 | Half of applied dead time, ticks |
| clamped | output | 1 | Ceiling was applied |
| zvs_ok | output | 1 | Soft-switching verdict |

## Verification
The latency, ceiling and verdict properties compare outputs with inputs sampled four edges earlier. They therefore assume that a sample's fields are presented in its valid cycle and that `meas_valid` is low throughout reset. The arithmetic assumes a nonzero `period` and a `t_phase` below it. The stimulus respects all of this: it drives one sample per valid cycle, releases reset before the first sample and picks phase times inside the period. It also keeps every verdict and clamp decision well away from its threshold, so that table quantisation cannot flip an expected flag.

// File: rtl/zdt_pkg.sv
package zdt_pkg;
    localparam int TW       = 16;
    localparam int VW       = 12;
    localparam int IW       = 12;
    localparam int LUT_AW   = 8;
    localparam int LUT_N    = 1 << LUT_AW;
    localparam int PHW      = LUT_AW + 2;
    localparam int SINW     = 16;
    localparam int SIN_FB   = 15;
    localparam int SIN_ONE  = (1 << SIN_FB) - 1;
    localparam int ARG_FB   = 12;
    localparam int ARGW     = ARG_FB + 1;
    localparam int ARG_ONE  = 1 << ARG_FB;
    localparam int FRW      = 16;
    localparam int FRAC_HALF = 1 << (FRW - 1);
    localparam int LATENCY  = 4;
    localparam longint HALF_PI_Q30 = 64'sd1686629713;

    typedef struct packed {
        logic [TW-1:0] period;
        logic [TW-1:0] t_phase;
        logic [TW-1:0] dt_max;
        logic [VW-1:0] vin;
        logic [IW-1:0] ipk;
    } meas_t;

    typedef struct packed {
        logic [TW-1:0] period;
        logic [TW-1:0] t_phase;
        logic [TW-1:0] dt_max;
    } timing_t;

    // sine of a Q30 angle (radians), Taylor series to x^13
    function automatic longint sin_q30(input longint x);
        longint x2, term, acc;
        x2   = (x * x) >>> 30;
        term = x;
        acc  = x;
        for (int k = 1; k <= 6; k++) begin
            term = -((term * x2) >>> 30) / longint'((2 * k) * (2 * k + 1));
            acc  = acc + term;
        end
        return acc;
    endfunction

    // quarter-wave sine table entry, Q15
    function automatic int sine_entry(input int i);
        return int'(sin_q30((HALF_PI_Q30 * longint'(i)) / longint'(LUT_N)) >>> SIN_FB);
    endfunction

    // arcsine table entry at bin centre, as a fraction of pi in Q16
    function automatic int asin_entry(input int i);
        longint lo, hi, mid, y;
        lo = 0;
        hi = HALF_PI_Q30;
        y  = longint'(2 * i + 1) <<< (30 - LUT_AW - 1);
        for (int n = 0; n < 26; n++) begin
            mid = (lo + hi) >>> 1;
            if (sin_q30(mid) <= y) lo = mid;
            else hi = mid;
        end
        return int'((lo <<< (FRW - 1)) / HALF_PI_Q30);
    endfunction
endpackage

// File: rtl/zdt_phase_sine.sv
module zdt_phase_sine
    import zdt_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  meas_t           in_meas,
    output logic            out_valid,
    output meas_t           out_meas,
    output logic [SINW-1:0] sin_mag
);
    logic [SINW-1:0] sin_rom [LUT_N];

    for (genvar g = 0; g < LUT_N; g++) begin : g_sin_rom
        localparam int SV = sine_entry(g);
        assign sin_rom[g] = SINW'(SV);
    end

    // stage 1: phase as a fraction of one turn
    logic [TW+PHW-1:0] ph_wide;
    logic [PHW-1:0]    ph_next;
    logic              s1_valid;
    meas_t             s1_meas;
    logic [PHW-1:0]    s1_ph;

    always_comb begin
        ph_wide = {in_meas.t_phase, {PHW{1'b0}}} / {{PHW{1'b0}}, in_meas.period};
        if (in_meas.period == '0 || in_meas.t_phase >= in_meas.period)
            ph_next = '1;
        else
            ph_next = PHW'(ph_wide);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            s1_meas  <= '0;
            s1_ph    <= '0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_meas <= in_meas;
                s1_ph   <= ph_next;
            end
        end
    end

    // stage 2: quadrant folding onto the quarter-wave table
    logic [1:0]        quad;
    logic [LUT_AW-1:0] idx, mir;
    logic [SINW-1:0]   sin_next;

    always_comb begin
        quad = s1_ph[PHW-1:PHW-2];
        idx  = s1_ph[LUT_AW-1:0];
        mir  = ~idx + LUT_AW'(1);
        if (!quad[0])          sin_next = sin_rom[idx];
        else if (idx == '0)    sin_next = SINW'(SIN_ONE);
        else                   sin_next = sin_rom[mir];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_meas  <= '0;
            sin_mag   <= '0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid) begin
                out_meas <= s1_meas;
                sin_mag  <= sin_next;
            end
        end
    end
endmodule

// File: rtl/zdt_arg_ratio.sv
module zdt_arg_ratio
    import zdt_pkg::*;
#(
    parameter int unsigned ARG_SCALE = 20600000
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  meas_t           in_meas,
    input  logic [SINW-1:0] sin_mag,
    output logic            out_valid,
    output timing_t         out_tm,
    output logic [ARGW-1:0] out_arg,
    output logic            out_sat
);
    localparam int NUMW = 32 + VW + SINW;
    localparam int DENW = IW + TW + SIN_FB;

    logic [NUMW-1:0] num, quo;
    logic [DENW-1:0] den;
    logic            sat_next;
    logic [ARGW-1:0] arg_next;

    always_comb begin
        num = NUMW'(ARG_SCALE) * NUMW'(in_meas.vin) * NUMW'(sin_mag);
        den = (DENW'(in_meas.ipk) * DENW'(in_meas.period)) << SIN_FB;
        quo = (den == '0) ? '1 : num / NUMW'(den);
        sat_next = (den == '0) || (quo >= NUMW'(ARG_ONE));
        arg_next = sat_next ? ARGW'(ARG_ONE) : ARGW'(quo);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_tm    <= '0;
            out_arg   <= '0;
            out_sat   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_tm  <= '{period: in_meas.period, t_phase: in_meas.t_phase,
                             dt_max: in_meas.dt_max};
                out_arg <= arg_next;
                out_sat <= sat_next;
            end
        end
    end
endmodule

// File: rtl/zdt_dead_out.sv
module zdt_dead_out
    import zdt_pkg::*;
#(
    parameter int MARGIN = 200
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  timing_t         in_tm,
    input  logic [ARGW-1:0] in_arg,
    input  logic            in_sat,
    output logic            out_valid,
    output logic [TW-1:0]   dead_time,
    output logic [TW-1:0]   half_dead,
    output logic            clamped,
    output logic            zvs_ok
);
    localparam int PRW = TW + FRW;
    localparam int APW = TW + 2;

    logic [FRW-1:0] asin_rom [LUT_N];

    for (genvar g = 0; g < LUT_N; g++) begin : g_asin_rom
        localparam int AV = asin_entry(g);
        assign asin_rom[g] = FRW'(AV);
    end

    logic              sat_all;
    logic [LUT_AW-1:0] idx;
    logic [FRW-1:0]    frac;
    logic [PRW-1:0]    prod;
    logic [APW-1:0]    applied;
    logic [TW-1:0]     dt_next, half_next;
    logic              clamp_next, zvs_next;

    always_comb begin
        sat_all    = in_sat || in_arg[ARGW-1];
        idx        = LUT_AW'(in_arg >> (ARG_FB - LUT_AW));
        frac       = sat_all ? FRW'(FRAC_HALF) : asin_rom[idx];
        prod       = PRW'(in_tm.period) * PRW'(frac);
        applied    = APW'(prod >> FRW) + APW'(MARGIN);
        clamp_next = applied > APW'(in_tm.dt_max);
        dt_next    = clamp_next ? in_tm.dt_max : TW'(applied);
        half_next  = dt_next >> 1;
        zvs_next   = !sat_all && (in_tm.t_phase >= half_next);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            dead_time <= '0;
            half_dead <= '0;
            clamped   <= 1'b0;
            zvs_ok    <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                dead_time <= dt_next;
                half_dead <= half_next;
                clamped   <= clamp_next;
                zvs_ok    <= zvs_next;
            end
        end
    end

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> ($stable(dead_time) && $stable(zvs_ok) && $stable(clamped)));
endmodule

// File: rtl/zvs_deadtime_calc.sv
module zvs_deadtime_calc
    import zdt_pkg::*;
#(
    parameter int          MARGIN    = 200,
    parameter int unsigned ARG_SCALE = 20600000
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          meas_valid,
    input  logic [TW-1:0] t_phase,
    input  logic [TW-1:0] period,
    input  logic [IW-1:0] i_peak,
    input  logic [VW-1:0] v_in,
    input  logic [TW-1:0] dt_limit,
    output logic          out_valid,
    output logic [TW-1:0] dead_time,
    output logic [TW-1:0] half_dead,
    output logic          clamped,
    output logic          zvs_ok
);
    meas_t           in_meas, ps_meas;
    logic            ps_valid, ar_valid, ar_sat;
    logic [SINW-1:0] ps_sin;
    timing_t         ar_tm;
    logic [ARGW-1:0] ar_arg;

    assign in_meas = '{period: period, t_phase: t_phase, dt_max: dt_limit,
                       vin: v_in, ipk: i_peak};

    zdt_phase_sine u_phase (
        .clk(clk), .rst(rst),
        .in_valid(meas_valid), .in_meas(in_meas),
        .out_valid(ps_valid), .out_meas(ps_meas), .sin_mag(ps_sin)
    );

    zdt_arg_ratio #(.ARG_SCALE(ARG_SCALE)) u_arg (
        .clk(clk), .rst(rst),
        .in_valid(ps_valid), .in_meas(ps_meas), .sin_mag(ps_sin),
        .out_valid(ar_valid), .out_tm(ar_tm), .out_arg(ar_arg), .out_sat(ar_sat)
    );

    zdt_dead_out #(.MARGIN(MARGIN)) u_out (
        .clk(clk), .rst(rst),
        .in_valid(ar_valid), .in_tm(ar_tm), .in_arg(ar_arg), .in_sat(ar_sat),
        .out_valid(out_valid), .dead_time(dead_time), .half_dead(half_dead),
        .clamped(clamped), .zvs_ok(zvs_ok)
    );

    p_latency_r1: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(meas_valid, LATENCY));

    p_ceiling_r5: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (dead_time <= $past(dt_limit, LATENCY)));

    p_verdict_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && zvs_ok) |-> ($past(t_phase, LATENCY) >= half_dead));

    p_margin_r2: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !clamped) |-> (int'(dead_time) >= MARGIN));
endmodule

// File: tb/sim_zvs_deadtime_calc.sv
module sim_zvs_deadtime_calc;
    localparam int          MARGIN    = 200;
    localparam int unsigned ARG_SCALE = 20600000;
    localparam real         PI        = 3.14159265358979;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        meas_valid = 1'b0;
    logic [15:0] t_phase = '0, period = '0, dt_limit = '0;
    logic [11:0] i_peak = '0, v_in = '0;
    logic        out_valid, clamped, zvs_ok;
    logic [15:0] dead_time, half_dead;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    typedef struct {
        int    cyc;
        int    dt;
        int    tol;
        bit    clamp;
        bit    zvs;
        string tag;
    } exp_t;
    exp_t exp_q[$];
    exp_t cur;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    zvs_deadtime_calc #(.MARGIN(MARGIN), .ARG_SCALE(ARG_SCALE)) u0 (
        .clk(clk), .rst(rst), .meas_valid(meas_valid),
        .t_phase(t_phase), .period(period), .i_peak(i_peak), .v_in(v_in),
        .dt_limit(dt_limit), .out_valid(out_valid), .dead_time(dead_time),
        .half_dead(half_dead), .clamped(clamped), .zvs_ok(zvs_ok)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // driver: computes the expected result and presents one sample
    task automatic send(input int tph, input int per, input int ip, input int vin,
                        input int lim, input string tag);
        real phi, s, a, dmin;
        bit sat;
        int app;
        exp_t e;
        phi = 2.0 * PI * real'(tph) / real'(per);
        s = $sin(phi);
        if (s < 0.0) s = -s;
        a = 0.0;
        if (ip == 0) sat = 1'b1;
        else begin
            a = real'(ARG_SCALE) * real'(vin) * s / (real'(ip) * real'(per) * 4096.0);
            sat = (a >= 1.0);
        end
        dmin = sat ? real'(per) / 2.0 : real'(per) / PI * $asin(a);
        app = $rtoi(dmin) + MARGIN;
        e.cyc   = cyc;
        e.clamp = (app > lim);
        e.dt    = e.clamp ? lim : app;
        e.tol   = e.clamp ? 0 : 16;
        e.zvs   = !sat && (tph >= e.dt / 2);
        e.tag   = tag;
        exp_q.push_back(e);
        t_phase  = 16'(tph);
        period   = 16'(per);
        i_peak   = 12'(ip);
        v_in     = 12'(vin);
        dt_limit = 16'(lim);
        meas_valid = 1'b1;
        @(negedge clk);
        meas_valid = 1'b0;
    endtask

    // monitor: pops expectations as results emerge
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (exp_q.size() == 0) chk(1'b0, "R1", "strobe without sample", 1, 0);
            else begin
                int diff;
                cur = exp_q.pop_front();
                chk(cyc == cur.cyc + 4, "R1", "latency", cyc - cur.cyc, 4);
                diff = int'(dead_time) - cur.dt;
                if (diff < 0) diff = -diff;
                chk(diff <= cur.tol, cur.tag, "dead_time", int'(dead_time), cur.dt);
                chk(clamped == cur.clamp, "R5", "clamped", int'(clamped), int'(cur.clamp));
                chk(int'(half_dead) == int'(dead_time) / 2, "R6", "half_dead",
                    int'(half_dead), int'(dead_time) / 2);
                chk(zvs_ok == cur.zvs, "R7", "zvs_ok", int'(zvs_ok), int'(cur.zvs));
            end
        end
    end

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic hold_check();
        logic [15:0] d0, h0;
        logic c0, z0;
        drain();
        d0 = dead_time; h0 = half_dead; c0 = clamped; z0 = zvs_ok;
        repeat (3) @(negedge clk);
        chk(dead_time == d0 && half_dead == h0 && clamped == c0 && zvs_ok == z0 && !out_valid,
            "R8", "outputs held", int'(dead_time), int'(d0));
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk(out_valid == 1'b0 && dead_time == '0, "R9", "in reset", int'(dead_time), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R9", "valid after reset", int'(out_valid), 0);
        chk(dead_time == '0 && half_dead == '0, "R9", "dead_time after reset", int'(dead_time), 0);
        chk(clamped == 1'b0 && zvs_ok == 1'b0, "R9", "flags after reset",
            int'({clamped, zvs_ok}), 0);

        send(833, 5000, 2000, 300, 2000, "R2");          // 60 deg
        hold_check();
        send(1667, 5000, 2000, 300, 2000, "R3");         // 120 deg
        send(3333, 5000, 2000, 300, 2000, "R3");         // 240 deg
        send(4167, 5000, 2000, 300, 2000, "R3");         // 300 deg
        drain();
        send(69, 5000, 2000, 300, 2000, "R7");           // small phase, not soft
        send(833, 5000, 372, 300, 2000, "R2");           // large argument
        send(500, 4000, 1500, 400, 2000, "R2");          // other period
        drain();
        send(2361, 5000, 50, 300, 4000, "R4");           // saturated argument
        send(833, 5000, 0, 300, 4000, "R4");             // zero current
        send(2361, 5000, 50, 300, 1200, "R5");           // saturated and clamped
        send(833, 5000, 372, 300, 1000, "R5");           // clamped, still soft
        hold_check();
        // back-to-back samples
        send(833, 5000, 2000, 300, 2000, "R1");
        send(69, 5000, 2000, 300, 2000, "R1");
        send(500, 4000, 1500, 400, 2000, "R1");
        hold_check();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule